// File: doc/BRIEF.md
# Dual-Mode Bit-Serial Adder

This block adds two unsigned numbers one bit per clock, least significant bit first. It uses one full adder and one carry flip-flop. There are two ways to use it. In word mode, two operand words are captured into shift registers and walked through the adder. The sum bits collect in a result register that is one bit wider than the operands, so the final carry fits. In stream mode, operand bits arrive on two serial pins and sum bits leave on a serial pin.

A single flag, `sum_ok`, marks good output in both modes. In word mode it rises once the result register is complete and stays high until the next load or reset. In stream mode it is the stream enable delayed by one cycle, which matches the one-cycle latency of the registered serial sum. The operand width is a parameter with a default of 4. A second parameter selects one of two equivalent ways of building the full adder.

Top module: `bit_serial_adder`

## Requirements
- R1: Reset is synchronous and active high. After a clock edge with `rst` high, `sum_ok`, `sum_bit` and `sum_word` are all 0.
- R2: A clock edge with `load_par` high captures `par_a` and `par_b` and starts a new addition with a carry-in of 0. `sum_ok` is 0 after that edge.
- R3: The W+1 edges that follow the load edge are all needed before the result is ready. After the W-th edge `sum_ok` is still 0. After the (W+1)-th edge `sum_word` equals `par_a + par_b` as a W+1-bit value, with the final carry in bit W, and `sum_ok` is 1.
- R4: Once a word-mode result is valid and neither control is high, `sum_ok` and `sum_word` keep their values whatever the serial inputs do.
- R5: Every load starts from a carry of 0. Back-to-back word additions are each correct, even when the one before ended with a carry of 1.
- R6: In stream mode, each edge with `stream_en` high (and `load_par` low) takes one bit from `ser_a` and one from `ser_b`. After edge k of a run, `sum_bit` holds bit k of the running sum, one cycle of latency.
- R7: During streaming, `sum_ok` is 1 after each accepted edge. After the first edge with `stream_en` low, `sum_ok` is 0.
- R8: When `stream_en` rises, the carry-in for the first accepted bit pair is 0, whatever carry the previous run left behind.
- R9: If `load_par` and `stream_en` are both high at an edge, the word load wins and the result follows R3.
- R10: A stream cycle during an unfinished word addition cancels that addition. `sum_ok` then follows R7 and does not rise later for the cancelled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_par | input | 1 | Capture operand words and start a word-mode addition |
| stream_en | input | 1 | Accept one serial bit pair per clock |
| ser_a | input | 1 | Serial operand A bit, LSB first |
| ser_b | input | 1 | Serial operand B bit, LSB first |
| par_a | input | W | Operand A word |
| par_b | input | W | Operand B word |
| sum_bit | output | 1 | Registered serial sum bit |
| sum_word | output | W+1 | Word-mode result including final carry |
| sum_ok | output | 1 | Output valid flag, qualified by mode |

## Verification
The hardest case to reach is a stale carry crossing from one stream run into the next. It only shows if a run ends with the carry flip-flop set and a fresh run starts right after a short gap. The stimulus streams operands chosen so that every bit position carries out. It then leaves one idle cycle and starts a run whose first bit pair sums to 1, so a carry that was not cleared would turn the first sum bit into 0. Mode contention gets directed sequences of its own: both controls high in one cycle, and a stream cycle issued in the middle of a word addition.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_LOAD   = 2'd1,
      ACT_SHIFT  = 2'd2,
      ACT_STREAM = 2'd3
   } bsa_act_e;

   function automatic int unsigned bsa_cnt_w(input int unsigned width);
      return $clog2(width + 2);
   endfunction

endpackage

// File: rtl/bsa_shift_reg.sv
module bsa_shift_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] load_val,
   input  logic             ser_in,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] shifted;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == WIDTH - 1) begin : g_top
         assign shifted[i] = ser_in;
      end else begin : g_mid
         assign shifted[i] = q[i+1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (shift) begin
         q <= shifted;
      end
   end

endmodule

// File: rtl/bsa_bit_core.sv
module bsa_bit_core
   import bsa_pkg::*;
#(
   parameter int unsigned SUM_STYLE = 0
) (
   input  logic     clk,
   input  logic     rst,
   input  bsa_act_e act,
   input  logic     first_stream,
   input  logic     par_a,
   input  logic     par_b,
   input  logic     ser_a,
   input  logic     ser_b,
   output logic     fa_sum,
   output logic     sum_bit
);

   logic carry_q;
   logic op_a;
   logic op_b;
   logic cin;
   logic cout;

   assign op_a = (act == ACT_SHIFT) ? par_a : ser_a;
   assign op_b = (act == ACT_SHIFT) ? par_b : ser_b;
   assign cin  = (act == ACT_LOAD || first_stream) ? 1'b0 : carry_q;

   if (SUM_STYLE == 0) begin : g_gates
      assign fa_sum = op_a ^ op_b ^ cin;
      assign cout   = (op_a & op_b) | (op_a & cin) | (op_b & cin);
   end else begin : g_arith
      logic [1:0] tot;
      assign tot    = {1'b0, op_a} + {1'b0, op_b} + {1'b0, cin};
      assign fa_sum = tot[0];
      assign cout   = tot[1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         carry_q <= 1'b0;
         sum_bit <= 1'b0;
      end else begin
         sum_bit <= fa_sum;
         case (act)
            ACT_LOAD:   carry_q <= 1'b0;
            ACT_SHIFT,
            ACT_STREAM: carry_q <= cout;
            default:    carry_q <= carry_q;
         endcase
      end
   end

   // R8: first accepted pair of a run sees carry-in 0
   assert_stream_cin_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_STREAM && first_stream) |=> (sum_bit == $past(ser_a ^ ser_b)));

endmodule

// File: rtl/bsa_seq_ctrl.sv
module bsa_seq_ctrl
   import bsa_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     load_par,
   input  logic     stream_en,
   output bsa_act_e act,
   output logic     first_stream,
   output logic     valid
);

   localparam int unsigned CW = bsa_cnt_w(W);
   localparam logic [CW-1:0] STEPS = CW'(W + 1);

   logic [CW-1:0] cnt;
   logic          stream_prev;

   always_comb begin
      if (load_par)         act = ACT_LOAD;
      else if (stream_en)   act = ACT_STREAM;
      else if (cnt != '0)   act = ACT_SHIFT;
      else                  act = ACT_IDLE;
   end

   assign first_stream = (act == ACT_STREAM) && !stream_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt         <= '0;
         valid       <= 1'b0;
         stream_prev <= 1'b0;
      end else begin
         stream_prev <= (act == ACT_STREAM);
         case (act)
            ACT_LOAD: begin
               cnt   <= STEPS;
               valid <= 1'b0;
            end
            ACT_SHIFT: begin
               cnt   <= cnt - 1'b1;
               valid <= (cnt == CW'(1));
            end
            ACT_STREAM: begin
               cnt   <= '0;
               valid <= 1'b1;
            end
            default: begin
               valid <= valid & ~stream_prev;
            end
         endcase
      end
   end

   // R3: the step counter never exceeds W+1
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= STEPS);

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
   import bsa_pkg::*;
#(
   parameter int unsigned W         = 4,
   parameter int unsigned SUM_STYLE = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_par,
   input  logic         stream_en,
   input  logic         ser_a,
   input  logic         ser_b,
   input  logic [W-1:0] par_a,
   input  logic [W-1:0] par_b,
   output logic         sum_bit,
   output logic [W:0]   sum_word,
   output logic         sum_ok
);

   if (W < 1) begin : g_bad_width
      $error("bit_serial_adder: W must be at least 1");
   end
   if (SUM_STYLE > 1) begin : g_bad_style
      $error("bit_serial_adder: SUM_STYLE must be 0 or 1");
   end

   bsa_act_e     act;
   logic         first_stream;
   logic         fa_sum;
   logic [W-1:0] a_q;
   logic [W-1:0] b_q;
   logic         unused_hi;

   assign unused_hi = ^{a_q, b_q};

   bsa_seq_ctrl #(.W(W)) u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .load_par     (load_par),
      .stream_en    (stream_en),
      .act          (act),
      .first_stream (first_stream),
      .valid        (sum_ok)
   );

   bsa_shift_reg #(.WIDTH(W)) u_sr_a (
      .clk      (clk),
      .rst      (rst),
      .load     (act == ACT_LOAD),
      .shift    (act == ACT_SHIFT),
      .load_val (par_a),
      .ser_in   (1'b0),
      .q        (a_q)
   );

   bsa_shift_reg #(.WIDTH(W)) u_sr_b (
      .clk      (clk),
      .rst      (rst),
      .load     (act == ACT_LOAD),
      .shift    (act == ACT_SHIFT),
      .load_val (par_b),
      .ser_in   (1'b0),
      .q        (b_q)
   );

   bsa_shift_reg #(.WIDTH(W + 1)) u_sr_sum (
      .clk      (clk),
      .rst      (rst),
      .load     (act == ACT_LOAD),
      .shift    (act == ACT_SHIFT),
      .load_val ('0),
      .ser_in   (fa_sum),
      .q        (sum_word)
   );

   bsa_bit_core #(.SUM_STYLE(SUM_STYLE)) u_core (
      .clk          (clk),
      .rst          (rst),
      .act          (act),
      .first_stream (first_stream),
      .par_a        (a_q[0]),
      .par_b        (b_q[0]),
      .ser_a        (ser_a),
      .ser_b        (ser_b),
      .fa_sum       (fa_sum),
      .sum_bit      (sum_bit)
   );

   // R2: a load always drops the valid flag on the next cycle
   assert_load_clears_ok_R2: assert property (@(posedge clk) disable iff (rst)
      load_par |=> !sum_ok);

   // R7: accepted stream cycle gives valid one cycle later
   assert_stream_ok_R7: assert property (@(posedge clk) disable iff (rst)
      (stream_en && !load_par) |=> sum_ok);

   // R7: end of a stream run drops valid
   assert_stream_end_R7: assert property (@(posedge clk) disable iff (rst)
      (!load_par && !stream_en && $past(stream_en && !load_par)) |=> !sum_ok);

   // R4: a finished word result holds while idle
   assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (sum_ok && !load_par && !stream_en && !$past(stream_en && !load_par))
      |=> (sum_ok && $stable(sum_word)));

endmodule

// File: tb/bit_serial_adder_bench.sv
module bit_serial_adder_bench;

   localparam int unsigned W          = 4;
   localparam time         CLK_PERIOD = 10;
   localparam int unsigned NVEC       = 8;

   // {a, b, expected sum}
   localparam logic [12:0] VEC [NVEC] = '{
      {4'd0,  4'd0,  5'd0 },
      {4'd1,  4'd1,  5'd2 },
      {4'd15, 4'd1,  5'd16},
      {4'd15, 4'd15, 5'd30},
      {4'd9,  4'd6,  5'd15},
      {4'd8,  4'd8,  5'd16},
      {4'd5,  4'd10, 5'd15},
      {4'd7,  4'd9,  5'd16}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_par = 1'b0;
   logic         stream_en = 1'b0;
   logic         ser_a = 1'b0;
   logic         ser_b = 1'b0;
   logic [W-1:0] par_a = '0;
   logic [W-1:0] par_b = '0;
   logic         sum_bit;
   logic [W:0]   sum_word;
   logic         sum_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bit_serial_adder #(.W(W)) u_bit_serial_adder (
      .clk       (clk),
      .rst       (rst),
      .load_par  (load_par),
      .stream_en (stream_en),
      .ser_a     (ser_a),
      .ser_b     (ser_b),
      .par_a     (par_a),
      .par_b     (par_b),
      .sum_bit   (sum_bit),
      .sum_word  (sum_word),
      .sum_ok    (sum_ok)
   );

   task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic word_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W:0] expected, input logic with_stream);
      @(negedge clk);
      load_par  = 1'b1;
      stream_en = with_stream;
      par_a     = a;
      par_b     = b;
      tick();
      chk("R2 ok low after load", sum_ok, 0);
      @(negedge clk);
      load_par  = 1'b0;
      stream_en = 1'b0;
      par_a     = ~a;
      par_b     = ~b;
      for (int i = 1; i <= W; i++) tick();
      chk("R3 ok still low after W edges", sum_ok, 0);
      tick();
      chk(with_stream ? "R9 ok after W+1 edges" : "R3 ok after W+1 edges", sum_ok, 1);
      chk(with_stream ? "R9 sum word" : "R3 R5 sum word", sum_word, expected);
   endtask

   task automatic stream_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W:0] expected);
      for (int k = 0; k <= W; k++) begin
         @(negedge clk);
         stream_en = 1'b1;
         ser_a     = (k < W) ? a[k] : 1'b0;
         ser_b     = (k < W) ? b[k] : 1'b0;
         tick();
         chk("R6 stream sum bit", sum_bit, expected[k]);
         chk("R7 ok while streaming", sum_ok, 1);
      end
      @(negedge clk);
      stream_en = 1'b0;
      tick();
      chk("R7 ok drops after stream", sum_ok, 0);
   endtask

   task automatic stream_bit(input logic a, input logic b);
      @(negedge clk);
      stream_en = 1'b1;
      ser_a     = a;
      ser_b     = b;
      tick();
   endtask

   initial begin
      logic [W:0] hold_word;
      tick();
      tick();
      // R1: reset state
      chk("R1 ok at reset", sum_ok, 0);
      chk("R1 bit at reset", sum_bit, 0);
      chk("R1 word at reset", sum_word, 0);
      @(negedge clk);
      rst = 1'b0;

      // R3 R5: word mode over the table, back to back
      foreach (VEC[i]) word_add(VEC[i][12:9], VEC[i][8:5], VEC[i][4:0], 1'b0);

      // R4: serial inputs toggle while idle, result holds
      hold_word = sum_word;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         ser_a = i[0];
         ser_b = ~i[1];
         tick();
         chk("R4 ok holds", sum_ok, 1);
         chk("R4 word holds", sum_word, hold_word);
      end

      // R6 R7: stream mode over the table
      foreach (VEC[i]) stream_add(VEC[i][12:9], VEC[i][8:5], VEC[i][4:0]);

      // R8: run ends with carry 1, gap, new run must start with carry 0
      stream_bit(1'b1, 1'b1);
      chk("R8 setup bit0", sum_bit, 0);
      stream_bit(1'b1, 1'b0);
      chk("R8 setup bit1", sum_bit, 0);
      stream_bit(1'b1, 1'b0);
      chk("R8 setup bit2", sum_bit, 0);
      @(negedge clk);
      stream_en = 1'b0;
      tick();
      chk("R8 ok low in gap", sum_ok, 0);
      stream_bit(1'b1, 1'b0);
      chk("R8 first bit of new run", sum_bit, 1);
      stream_bit(1'b0, 1'b0);
      chk("R8 second bit of new run", sum_bit, 0);
      @(negedge clk);
      stream_en = 1'b0;
      tick();

      // R9: both controls high, word load wins
      word_add(4'd11, 4'd7, 5'd18, 1'b1);

      // R10: stream cycle during unfinished word addition
      @(negedge clk);
      load_par = 1'b1;
      par_a    = 4'd3;
      par_b    = 4'd4;
      tick();
      @(negedge clk);
      load_par = 1'b0;
      tick();
      tick();
      stream_bit(1'b1, 1'b1);
      chk("R10 ok from stream", sum_ok, 1);
      chk("R10 stream bit", sum_bit, 0);
      @(negedge clk);
      stream_en = 1'b0;
      tick();
      chk("R10 ok drops", sum_ok, 0);
      for (int i = 0; i < W + 2; i++) tick();
      chk("R10 cancelled word never valid", sum_ok, 0);

      // R1: reset in the middle of a valid result
      word_add(4'd6, 4'd5, 5'd11, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      tick();
      chk("R1 ok after mid reset", sum_ok, 0);
      chk("R1 word after mid reset", sum_word, 0);
      chk("R1 bit after mid reset", sum_bit, 0);
      @(negedge clk);
      rst = 1'b0;
      tick();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule